// File: doc/BRIEF.md
# Fixed-Point QR Eigenvalue Engine

This block finds the eigenvalues of a small symmetric positive-definite matrix, such as a covariance matrix, by running the unshifted QR iteration in fixed point. Software or a neighbouring block writes the matrix one element at a time through a load port. It then pulses `start` and supplies a tolerance. Each iteration factors the working matrix as Q·R with modified Gram-Schmidt and replaces it with R·Q. The iteration repeats until every entry below the diagonal is smaller in magnitude than the tolerance. The diagonal of the working matrix is visible on the output at all times. Once the run finishes, the diagonal holds the eigenvalues.

A single multiplier and a single accumulator are shared across four Gram-Schmidt operations: the column sum of squares, the column dot product, the column update and the R·Q product. A bit-serial square-root unit and a bit-serial divider each sit behind a go/valid handshake. One comparator screens each newly produced sub-diagonal entry against the tolerance. A second comparator catches a square-root result of zero, which would otherwise lead to a division by zero. An iteration cap bounds the run time.

Top module: `qr_eig_unit`

## Requirements
- R1: After reset, `busy`, `done`, `converged`, `max_hit` and `zero_err` are 0, `iter_cnt` is 0 and every lane of `eig` is 0.
- R2: While `busy` is 0, a cycle with `ld_en` high writes `ld_data` (signed, W bits, F fraction bits) to element (`ld_row`, `ld_col`). Lane i of `eig` (bits i·W to i·W+W−1) always shows diagonal element (i,i).
- R3: Every iteration follows modified Gram-Schmidt exactly. The column norm is the floor square root of the raw sum of full-precision products. Normalisation is (x·2^F)/norm, truncated toward zero. Each R entry, each column-update product and each R·Q entry is a full-precision sum shifted right by F with floor rounding, kept to W bits.
- R4: A run stops after the first iteration in which every entry (i,j) with i > j has magnitude below `tol`. `converged` is then set, and `iter_cnt` equals the number of iterations performed.
- R5: A diagonal matrix with a nonzero tolerance finishes after exactly one iteration, and its diagonal is unchanged.
- R6: If MAX_ITER iterations pass without convergence, the run stops with `max_hit` set and `iter_cnt` equal to MAX_ITER.
- R7: A column norm whose square root is 0 stops the run with `zero_err` set, and no division takes place. If this happens in the first iteration, the loaded matrix stays unchanged and `iter_cnt` is 0.
- R8: `busy` rises only in response to `start` and stays high until `done` rises. `done` then holds until the next `start`. Loads presented while `busy` is high are ignored.
- R9: For a converged matrix with well-separated eigenvalues, the output lanes come out in strictly decreasing order from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Matrix element write strobe |
| ld_row | input | clog2(N) | Row index of the write |
| ld_col | input | clog2(N) | Column index of the write |
| ld_data | input | W | Signed fixed-point element value |
| start | input | 1 | Begin a run (accepted when idle) |
| tol | input | W | Unsigned magnitude bound for sub-diagonal entries |
| eig | output | N·W | Diagonal of the working matrix, lane i is element (i,i) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| iter_cnt | output | clog2(MAX_ITER+1) | Completed QR iterations |
| converged | output | 1 | Run ended by the tolerance test |
| max_hit | output | 1 | Run ended by the iteration cap |
| zero_err | output | 1 | Run ended by a zero column norm |

## Verification
The assertions check several properties on every cycle. `busy` and `done` are never high together, and at most one ending flag is set. A zero norm always leads to the abort on the next cycle, and the iteration cap matches the count. The square root is bracketed by its radicand, and the divider satisfies quotient·divisor + remainder = dividend with the remainder below the divisor. Whether the whole chain of rounding choices yields the right eigenvalues and iteration count cannot be seen locally, so only the bench's scenarios show it. The bench compares against an independent model for diagonal, banded, random, capped and rank-deficient matrices, and it also issues a load while a run is in progress.

// File: rtl/qr_eig_pkg.sv
package qr_eig_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_COPY,
    ST_NSQ,
    ST_SQRT,
    ST_DIV,
    ST_DOT,
    ST_UPD,
    ST_RQ,
    ST_CHK
  } qr_state_e;

endpackage

// File: rtl/qr_isqrt.sv
module qr_isqrt #(
  parameter int XW = 44,
  parameter int OW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [XW-1:0] x,
  output logic          vld,
  output logic [OW-1:0] root
);
  localparam int RW  = XW / 2;
  localparam int CNW = $clog2(RW + 1);

  logic [XW-1:0]  xs, x0;
  logic [RW+2:0]  rem;
  logic [RW-1:0]  rt;
  logic [CNW-1:0] cnt;
  logic           run;

  wire [RW+2:0] rem_sh = {rem[RW:0], xs[XW-1:XW-2]};
  wire [RW+2:0] trial  = {1'b0, rt, 2'b01};
  wire          take   = rem_sh >= trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs <= '0; x0 <= '0; rem <= '0; rt <= '0; cnt <= '0; run <= 1'b0; vld <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (!run) begin
        if (go) begin
          xs  <= x;
          x0  <= x;
          rem <= '0;
          rt  <= '0;
          cnt <= CNW'(RW);
          run <= 1'b1;
        end
      end else begin
        rem <= take ? rem_sh - trial : rem_sh;
        rt  <= {rt[RW-2:0], take};
        xs  <= xs << 2;
        cnt <= cnt - CNW'(1);
        if (cnt == CNW'(1)) begin
          run <= 1'b0;
          vld <= 1'b1;
        end
      end
    end
  end

  assign root = rt[OW-1:0];

  wire [XW+1:0] sq_lo = (XW+2)'(rt) * (XW+2)'(rt);
  wire [XW+1:0] sq_hi = ((XW+2)'(rt) + (XW+2)'(1)) * ((XW+2)'(rt) + (XW+2)'(1));

  // R3
  sqrt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (sq_lo <= (XW+2)'(x0)) && (sq_hi > (XW+2)'(x0)));
endmodule

// File: rtl/qr_udiv.sv
module qr_udiv #(
  parameter int NW = 30,
  parameter int DW = 20,
  parameter int OW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          vld,
  output logic [OW-1:0] quo
);
  localparam int CNW = $clog2(NW + 1);

  logic [NW-1:0]  qs, n0;
  logic [DW-1:0]  rem, dv;
  logic [CNW-1:0] cnt;
  logic           run;

  wire [DW:0] rem_sh = {rem, qs[NW-1]};
  wire        take   = rem_sh >= {1'b0, dv};
  wire [DW:0] diff   = rem_sh - {1'b0, dv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qs <= '0; n0 <= '0; rem <= '0; dv <= '0; cnt <= '0; run <= 1'b0; vld <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (!run) begin
        if (go) begin
          qs  <= num;
          n0  <= num;
          dv  <= den;
          rem <= '0;
          cnt <= CNW'(NW);
          run <= 1'b1;
        end
      end else begin
        rem <= take ? diff[DW-1:0] : rem_sh[DW-1:0];
        qs  <= {qs[NW-2:0], take};
        cnt <= cnt - CNW'(1);
        if (cnt == CNW'(1)) begin
          run <= 1'b0;
          vld <= 1'b1;
        end
      end
    end
  end

  assign quo = qs[OW-1:0];

  // R3
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((NW+DW)'(qs) * (NW+DW)'(dv) + (NW+DW)'(rem) == (NW+DW)'(n0)) && (rem < dv));
endmodule

// File: rtl/qr_eig_unit.sv
module qr_eig_unit
  import qr_eig_pkg::*;
#(
  parameter int N        = 4,
  parameter int W        = 20,
  parameter int F        = 10,
  parameter int MAX_ITER = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [$clog2(N)-1:0]          ld_row,
  input  logic [$clog2(N)-1:0]          ld_col,
  input  logic [W-1:0]                  ld_data,
  input  logic                          start,
  input  logic [W-1:0]                  tol,
  output logic [N*W-1:0]                eig,
  output logic                          busy,
  output logic                          done,
  output logic [$clog2(MAX_ITER+1)-1:0] iter_cnt,
  output logic                          converged,
  output logic                          max_hit,
  output logic                          zero_err
);
  localparam int LW = $clog2(N);
  localparam int AW = 2 * (W + LW);
  localparam int NW = W + F;
  localparam int CW = $clog2(MAX_ITER + 1);
  localparam logic [LW-1:0] LAST = LW'(N - 1);
  localparam logic [LW-1:0] STEP = LW'(1);

  typedef logic signed [W-1:0]  word_t;
  typedef logic signed [AW-1:0] wide_t;

  // Floor rescale of a full-precision sum back to a W-bit word.
  function automatic word_t fx_scale(input wide_t v);
    return word_t'(v >>> F);
  endfunction

  function automatic logic [W-1:0] fx_mag(input word_t v);
    return v[W-1] ? $unsigned(-v) : $unsigned(v);
  endfunction

  word_t a_m [N][N];
  word_t q_m [N][N];
  word_t r_m [N][N];

  qr_state_e       st;
  logic [LW-1:0]   i_q, j_q, k_q, ri_q, ci_q;
  wide_t           acc;
  logic            pend, nconv;

  // Shared datapath operands
  word_t                 mul_a, mul_b;
  logic signed [2*W-1:0] prod;
  wide_t                 prod_x, acc_base, acc_nxt;

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    unique case (st)
      ST_NSQ: begin mul_a = q_m[i_q][j_q];  mul_b = q_m[i_q][j_q];  end
      ST_DOT: begin mul_a = q_m[i_q][j_q];  mul_b = q_m[i_q][k_q];  end
      ST_UPD: begin mul_a = r_m[j_q][k_q];  mul_b = q_m[i_q][j_q];  end
      ST_RQ:  begin mul_a = r_m[ri_q][i_q]; mul_b = q_m[i_q][ci_q]; end
      default: ;
    endcase
  end

  assign prod     = mul_a * mul_b;
  assign prod_x   = wide_t'(prod);
  assign acc_base = (i_q == '0) ? wide_t'(0) : acc;
  assign acc_nxt  = acc_base + prod_x;

  // Square root and divider behind go/valid handshakes
  logic         sq_go, sq_vld, dv_go, dv_vld;
  logic [W-1:0] sq_root, dv_quo;
  word_t        qv, dv_word, upd_val, rq_val;
  logic [W-1:0] q_mag;
  logic [NW-1:0] dv_num;

  assign sq_go   = (st == ST_SQRT) && !pend;
  assign dv_go   = (st == ST_DIV) && !pend;
  assign qv      = q_m[i_q][j_q];
  assign q_mag   = fx_mag(qv);
  assign dv_num  = {q_mag, {F{1'b0}}};
  assign dv_word = qv[W-1] ? -word_t'(dv_quo) : word_t'(dv_quo);
  assign upd_val = q_m[i_q][k_q] - fx_scale(prod_x);
  assign rq_val  = fx_scale(acc_nxt);

  qr_isqrt #(.XW(AW), .OW(W)) u_sqrt (
    .clk(clk), .rst_n(rst_n), .go(sq_go), .x($unsigned(acc)), .vld(sq_vld), .root(sq_root)
  );

  qr_udiv #(.NW(NW), .DW(W), .OW(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dv_go), .num(dv_num), .den($unsigned(r_m[j_q][j_q])),
    .vld(dv_vld), .quo(dv_quo)
  );

  // Named events for the assertions
  logic rq_last, sub_big, zero_norm_hit;
  assign rq_last       = (st == ST_RQ) && (i_q == LAST);
  assign sub_big       = rq_last && (ri_q > ci_q) && (fx_mag(rq_val) >= tol);
  assign zero_norm_hit = (st == ST_SQRT) && sq_vld && (sq_root == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; busy <= 1'b0; done <= 1'b0; iter_cnt <= '0;
      converged <= 1'b0; max_hit <= 1'b0; zero_err <= 1'b0;
      i_q <= '0; j_q <= '0; k_q <= '0; ri_q <= '0; ci_q <= '0;
      acc <= '0; pend <= 1'b0; nconv <= 1'b0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          a_m[r][c] <= '0; q_m[r][c] <= '0; r_m[r][c] <= '0;
        end
    end else begin
      if (ld_en && !busy) a_m[ld_row][ld_col] <= word_t'(ld_data);
      unique case (st)
        ST_IDLE: if (start) begin
          busy <= 1'b1; done <= 1'b0; iter_cnt <= '0;
          converged <= 1'b0; max_hit <= 1'b0; zero_err <= 1'b0;
          st <= ST_COPY;
        end
        ST_COPY: begin
          for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
              q_m[r][c] <= a_m[r][c];
              r_m[r][c] <= '0;
            end
          j_q <= '0; i_q <= '0; nconv <= 1'b0;
          st <= ST_NSQ;
        end
        ST_NSQ: begin
          acc <= acc_nxt;
          if (i_q == LAST) begin i_q <= '0; st <= ST_SQRT; end
          else i_q <= i_q + STEP;
        end
        ST_SQRT: begin
          if (sq_go) pend <= 1'b1;
          if (sq_vld) begin
            pend <= 1'b0;
            if (zero_norm_hit) begin
              zero_err <= 1'b1; done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
            end else begin
              r_m[j_q][j_q] <= word_t'(sq_root);
              st <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (dv_go) pend <= 1'b1;
          if (dv_vld) begin
            pend <= 1'b0;
            q_m[i_q][j_q] <= dv_word;
            if (i_q == LAST) begin
              i_q <= '0;
              if (j_q == LAST) begin ri_q <= '0; ci_q <= '0; st <= ST_RQ; end
              else begin k_q <= j_q + STEP; st <= ST_DOT; end
            end else i_q <= i_q + STEP;
          end
        end
        ST_DOT: begin
          acc <= acc_nxt;
          if (i_q == LAST) begin
            r_m[j_q][k_q] <= fx_scale(acc_nxt);
            i_q <= '0; st <= ST_UPD;
          end else i_q <= i_q + STEP;
        end
        ST_UPD: begin
          q_m[i_q][k_q] <= upd_val;
          if (i_q == LAST) begin
            i_q <= '0;
            if (k_q == LAST) begin j_q <= j_q + STEP; st <= ST_NSQ; end
            else begin k_q <= k_q + STEP; st <= ST_DOT; end
          end else i_q <= i_q + STEP;
        end
        ST_RQ: begin
          acc <= acc_nxt;
          if (rq_last) begin
            a_m[ri_q][ci_q] <= rq_val;
            if (sub_big) nconv <= 1'b1;
            i_q <= '0;
            if (ci_q == LAST) begin
              ci_q <= '0;
              if (ri_q == LAST) begin iter_cnt <= iter_cnt + CW'(1); st <= ST_CHK; end
              else ri_q <= ri_q + STEP;
            end else ci_q <= ci_q + STEP;
          end else i_q <= i_q + STEP;
        end
        ST_CHK: begin
          if (!nconv) begin
            converged <= 1'b1; done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else if (iter_cnt == CW'(MAX_ITER)) begin
            max_hit <= 1'b1; done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else st <= ST_COPY;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_diag
    assign eig[g*W +: W] = a_m[g][g];
  end

  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R7
  zero_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_norm_hit |=> (zero_err && done && !busy));
  // R6
  max_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_hit |-> (iter_cnt == CW'(MAX_ITER)));
  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({converged, max_hit, zero_err}));
  // R4
  conv_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(converged) |-> done);
endmodule

// File: tb/sim_qr_eig_unit.sv
module sim_qr_eig_unit;
  localparam int N    = 4;
  localparam int W    = 20;
  localparam int F    = 10;
  localparam int MAXI = 20;
  localparam int CW   = $clog2(MAXI + 1);
  localparam longint ONE = 64'sd1 << F;
  localparam int WD_LIMIT = 40000;

  logic clk = 0, rst_n = 0, ld_en = 0, start = 0;
  logic [$clog2(N)-1:0] ld_row = '0, ld_col = '0;
  logic [W-1:0] ld_data = '0, tol = '0;
  logic [N*W-1:0] eig;
  logic busy, done, converged, max_hit, zero_err;
  logic [CW-1:0] iter_cnt;

  always #10 clk = ~clk;

  qr_eig_unit #(.N(N), .W(W), .F(F), .MAX_ITER(MAXI)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col),
    .ld_data(ld_data), .start(start), .tol(tol), .eig(eig), .busy(busy), .done(done),
    .iter_cnt(iter_cnt), .converged(converged), .max_hit(max_hit), .zero_err(zero_err)
  );

  int n_tests = 0, n_fail = 0;
  longint ain [N][N];
  longint ma [N][N], mq [N][N], mr [N][N];
  longint exp_diag [N];
  longint exp_iter, exp_conv, exp_max, exp_zero;

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic longint wrapw(input longint x);
    longint m;
    m = x & ((64'sd1 <<< W) - 1);
    if (m >= (64'sd1 <<< (W - 1))) m = m - (64'sd1 <<< W);
    return m;
  endfunction

  function automatic longint fl(input longint x);
    longint q;
    q = x / ONE;
    if ((x % ONE) != 0 && x < 0) q = q - 1;
    return wrapw(q);
  endfunction

  function automatic longint bsqrt(input longint s);
    longint lo, hi, mid;
    lo = 0; hi = 64'sd1 << 24;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= s) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic longint babs(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic longint lane(input int i);
    return wrapw(longint'(eig[i*W +: W]));
  endfunction

  // Independent model of the requirement R3/R4/R6/R7 rules
  task automatic model(input longint t);
    longint s, r, d;
    bit nc;
    exp_iter = 0; exp_conv = 0; exp_max = 0; exp_zero = 0;
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) ma[a][b] = ain[a][b];
    for (int it = 0; it < MAXI && exp_conv == 0 && exp_zero == 0; it++) begin
      for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) begin
        mq[a][b] = ma[a][b]; mr[a][b] = 0;
      end
      for (int j = 0; j < N && exp_zero == 0; j++) begin
        s = 0;
        for (int i = 0; i < N; i++) s += mq[i][j] * mq[i][j];
        r = wrapw(bsqrt(s));
        if (r == 0) exp_zero = 1;
        else begin
          mr[j][j] = r;
          for (int i = 0; i < N; i++) mq[i][j] = wrapw((mq[i][j] * ONE) / r);
          for (int k = j + 1; k < N; k++) begin
            d = 0;
            for (int i = 0; i < N; i++) d += mq[i][j] * mq[i][k];
            mr[j][k] = fl(d);
            for (int i = 0; i < N; i++) mq[i][k] = wrapw(mq[i][k] - fl(mr[j][k] * mq[i][j]));
          end
        end
      end
      if (exp_zero == 0) begin
        nc = 0;
        for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) begin
          d = 0;
          for (int k = 0; k < N; k++) d += mr[a][k] * mq[k][b];
          ma[a][b] = fl(d);
          if (a > b && babs(ma[a][b]) >= t) nc = 1;
        end
        exp_iter++;
        if (!nc) exp_conv = 1;
      end
    end
    if (exp_conv == 0 && exp_zero == 0) exp_max = 1;
    for (int i = 0; i < N; i++) exp_diag[i] = ma[i][i];
  endtask

  task automatic load_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        ld_en = 1; ld_row = r[$clog2(N)-1:0]; ld_col = c[$clog2(N)-1:0];
        ld_data = ain[r][c][W-1:0];
      end
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic run(input longint t, input bit poke);
    int wd;
    tol = t[W-1:0];
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R8", "busy after start", busy, 1);
    chk("R8", "done cleared", done, 0);
    if (poke) begin
      ld_en = 1; ld_row = 1; ld_col = 1; ld_data = 20'd12345;
      @(negedge clk); ld_en = 0;
    end
    wd = 0;
    while (!done && wd < WD_LIMIT) begin @(negedge clk); wd++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog: actual 0 expected 1");
    end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < N; i++) chk(req, "eig lane", lane(i), exp_diag[i]);
    chk(req, "iter_cnt", iter_cnt, exp_iter);
    chk(req, "converged", converged, exp_conv);
    chk(req, "max_hit", max_hit, exp_max);
    chk(req, "zero_err", zero_err, exp_zero);
  endtask

  task automatic clear_ain();
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) ain[a][b] = 0;
  endtask

  task automatic banded();
    clear_ain();
    ain[0][0] = 8 * ONE; ain[1][1] = 4 * ONE; ain[2][2] = 2 * ONE; ain[3][3] = ONE;
    for (int i = 0; i < N - 1; i++) begin ain[i][i+1] = ONE / 4; ain[i+1][i] = ONE / 4; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "iter_cnt", iter_cnt, 0);
    chk("R1", "flags", {converged, max_hit, zero_err}, 0);
    chk("R1", "eig", eig, 0);
    rst_n = 1;

    // R2 and R5: diagonal matrix
    clear_ain();
    ain[0][0] = 5 * ONE; ain[1][1] = 3 * ONE + 17; ain[2][2] = 2 * ONE; ain[3][3] = 700;
    load_all();
    for (int i = 0; i < N; i++) chk("R2", "loaded diag", lane(i), ain[i][i]);
    model(4);
    run(4, 0);
    chk("R5", "one iteration", iter_cnt, 1);
    chk("R5", "converged", converged, 1);
    for (int i = 0; i < N; i++) chk("R5", "diag kept", lane(i), ain[i][i]);

    // R4 and R9: banded matrix with separated eigenvalues
    banded();
    load_all();
    model(30);
    run(30, 0);
    compare("R4");
    chk("R4", "converged", converged, 1);
    for (int i = 0; i < N - 1; i++) chk("R9", "descending", lane(i) > lane(i + 1), 1);

    // R6: zero tolerance never converges
    load_all();
    model(0);
    run(0, 0);
    compare("R6");
    chk("R6", "cap count", iter_cnt, MAXI);
    chk("R6", "max_hit", max_hit, 1);

    // R7: zero first column and row
    clear_ain();
    ain[1][1] = 2 * ONE; ain[2][2] = 3 * ONE; ain[3][3] = 4 * ONE;
    ain[2][3] = ONE / 2; ain[3][2] = ONE / 2;
    load_all();
    run(16, 0);
    chk("R7", "zero_err", zero_err, 1);
    chk("R7", "iter_cnt", iter_cnt, 0);
    for (int i = 0; i < N; i++) chk("R7", "matrix untouched", lane(i), ain[i][i]);

    // R3 random symmetric diagonally dominant matrices; first one also pokes the load port (R8)
    for (int n = 0; n < 5; n++) begin
      longint t;
      clear_ain();
      for (int a = 0; a < N; a++) begin
        ain[a][a] = longint'($urandom_range(6 * 1024, 1024));
        for (int b = a + 1; b < N; b++) begin
          ain[a][b] = longint'($urandom_range(600, 0)) - 300;
          ain[b][a] = ain[a][b];
        end
      end
      t = longint'($urandom_range(40, 8));
      load_all();
      model(t);
      run(t, n == 0);
      compare(n == 0 ? "R8" : "R3");
    end

    // R8: done holds until next start
    repeat (3) @(negedge clk);
    chk("R8", "done held", done, 1);
    chk("R8", "busy low", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule